// File: doc/BRIEF.md
# Tiled Surface Address Generator

This block turns an element coordinate on a two-dimensional surface into a byte offset from the surface base address. Each request carries the element column and row, the log2 of the element size in bytes, the row pitch in bytes, a layout mode and a swizzle enable. The supported layouts are plain row-major, and four tiled layouts in which the surface is cut into 4 KB tiles. The tiles follow one another row-major across the surface, and each tiled layout has its own way of scattering bytes inside a tile.

The offset inside a tile is formed by routing the bits of the in-tile byte column (u) and in-tile row (v) to fixed address bit positions, so no divider or modulo unit is needed. The block finds the tile that holds the element, computes that tile's start from the pitch, inserts the in-tile offset, and, if enabled, folds higher address bits into bit 6 to spread traffic over memory channels.

Requests enter through a valid/ready handshake. The result appears three clock edges later through a valid/ready output, and a full pipeline stalls as a whole while the output is not taken.

Top module: `tileAddrGen`

## Requirements
- R1: Mode code 0 (and the unused codes 5, 6, 7) is row-major: offset = y*pitch + (x << elemLog2), and the swizzle enable has no effect.
- R2: Mode code 1 uses 512 B x 8 row tiles. tileCol = byteCol>>9 and tileRow = y>>3. Offset = tileRow*pitch*8 + tileCol*4096 + intra, where intra bits 11..0 are v2 v1 v0 u8..u0.
- R3: Mode code 2 uses 128 B x 32 row tiles. tileCol = byteCol>>7 and tileRow = y>>5. Tile start = tileRow*pitch*32 + tileCol*4096, and intra bits 11..0 are u6 u5 u4 v4..v0 u3..u0.
- R4: Mode code 4 has the same tile footprint and tile start as code 2, but intra bits 11..0 are v4 v3 u6 v2 u5 u4 v1 v0 u3 u2 u1 u0.
- R5: Mode code 3 uses tiles that hold 64x64 one-byte elements. tileCol = byteCol>>6 and tileRow = y>>6. Tile start = tileRow*pitch*32 + tileCol*4096, where the pitch is programmed at twice the logical byte width. Intra bits 11..0 are u5 u4 u3 v5 v4 v3 v2 u2 v1 u1 v0 u0.
- R6: The byte column is x shifted left by elemLog2 (0 to 4; larger values act as 4). In the in-tile part, the low elemLog2 bits are therefore zero.
- R7: In mode 1 with the swizzle off, two vertically adjacent elements of one tile are exactly 512 bytes apart.
- R8: In mode 1 with the swizzle enabled, bit 6 of the final offset is XORed with bits 9 and 10.
- R9: In mode 2 with the swizzle enabled, bit 6 is XORed with bit 9 alone. Modes 3 and 4 ignore the swizzle enable.
- R10: A request accepted at one rising edge gives outValid with its offset after the second following edge. With outReady held high, one request per cycle flows through in order.
- R11: While outValid is high and outReady is low, outOffset and outValid hold and inReady is low. No result is lost or duplicated.
- R12: After reset, outValid is low and inReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Request accepted when high together with inValid |
| inX | input | COORD_W | Element column |
| inY | input | COORD_W | Element row |
| inElemLog2 | input | 3 | log2 of element bytes (0..4) |
| inPitch | input | PITCH_W | Row pitch in bytes |
| inMode | input | 3 | Layout: 0 row-major, 1 512x8 tile, 2 128x32 column tile, 3 interleaved 64x64 tile, 4 shuffled 128x32 tile |
| inSwizzleEn | input | 1 | Enable bit-6 channel swizzle |
| outValid | output | 1 | Offset valid |
| outReady | input | 1 | Consumer takes offset |
| outOffset | output | ADDR_W | Byte offset from surface base |

## Verification
Each layout is driven with coordinates whose u and v bits sit both inside the first tile and past tile boundaries in both directions, so a misrouted bit, a wrong tile shift or a wrong physical row count gives a different offset. The interleaved 64x64 mode is driven past row 64, which separates logical from physical tile height. Element sizes of 4, 8 and 16 bytes show that the column is scaled before the tile split. Vertical neighbour pairs in the 512x8 mode check the fixed row stride. Swizzle runs pick offsets with bits 9 and 10 set in every mix, which tells the two swizzle forms apart, and the same requests are sent to the modes that must ignore the swizzle. A stalled back-to-back burst checks that results are held, kept in order and not lost.

// File: rtl/tagPkg.sv
package tagPkg;

  typedef enum logic [2:0] {
    MODE_LINEAR = 3'd0,
    MODE_XT     = 3'd1,
    MODE_YT     = 3'd2,
    MODE_WT     = 3'd3,
    MODE_T4     = 3'd4
  } tagMode_e;

  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
  } tagStrobe_t;

  localparam int TILE_BYTES_LOG2 = 12;
  localparam int MAX_ELEM_LOG2   = 4;

  // log2 of the tile width in byte columns
  function automatic logic [3:0] tileWidthLog2(input tagMode_e m);
    case (m)
      MODE_XT: tileWidthLog2 = 4'd9;
      MODE_WT: tileWidthLog2 = 4'd6;
      MODE_YT, MODE_T4: tileWidthLog2 = 4'd7;
      default: tileWidthLog2 = 4'd0;
    endcase
  endfunction

  // log2 of the tile height in logical element rows
  function automatic logic [3:0] tileHeightLog2(input tagMode_e m);
    case (m)
      MODE_XT: tileHeightLog2 = 4'd3;
      MODE_WT: tileHeightLog2 = 4'd6;
      MODE_YT, MODE_T4: tileHeightLog2 = 4'd5;
      default: tileHeightLog2 = 4'd0;
    endcase
  endfunction

  // log2 of the physical rows of pitch covered by one tile row
  function automatic logic [3:0] physRowsLog2(input tagMode_e m);
    case (m)
      MODE_XT: physRowsLog2 = 4'd3;
      MODE_YT, MODE_T4, MODE_WT: physRowsLog2 = 4'd5;
      default: physRowsLog2 = 4'd0;
    endcase
  endfunction

  // route in-tile column (u) and row (v) bits to the 12-bit tile offset
  function automatic logic [11:0] intraOffset(input tagMode_e m,
                                              input logic [8:0] u,
                                              input logic [5:0] v);
    case (m)
      MODE_XT: intraOffset = {v[2:0], u[8:0]};
      MODE_YT: intraOffset = {u[6:4], v[4:0], u[3:0]};
      MODE_T4: intraOffset = {v[4:3], u[6], v[2], u[5:4], v[1:0], u[3:0]};
      MODE_WT: intraOffset = {u[5:3], v[5:2], u[2], v[1], u[1], v[0], u[0]};
      default: intraOffset = 12'd0;
    endcase
  endfunction

endpackage

// File: rtl/tagCtrl.sv
module tagCtrl
  import tagPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output tagStrobe_t strobe
);

  logic vld1, vld2, vld3;
  logic advance;

  // the whole pipe moves whenever the last stage is empty or drained
  assign advance = !vld3 || outReady;

  always_comb begin
    strobe.ld1 = advance;
    strobe.ld2 = advance;
    strobe.ld3 = advance;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld1 <= 1'b0;
      vld2 <= 1'b0;
      vld3 <= 1'b0;
    end else if (advance) begin
      vld1 <= inValid;
      vld2 <= vld1;
      vld3 <= vld2;
    end
  end

  assign inReady  = advance;
  assign outValid = vld3;

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> vld1);

  assert_progress_R10: assert property (@(posedge clk) disable iff (!rstN)
    (vld2 && outReady) |=> outValid);

  assert_backpressure_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  assert_holdvalid_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

endmodule

// File: rtl/tagDatapath.sv
module tagDatapath
  import tagPkg::*;
#(
  parameter int COORD_W = 16,
  parameter int PITCH_W = 20,
  parameter int ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  tagStrobe_t         strobe,
  input  logic [COORD_W-1:0] inX,
  input  logic [COORD_W-1:0] inY,
  input  logic [2:0]         inElemLog2,
  input  logic [PITCH_W-1:0] inPitch,
  input  logic [2:0]         inMode,
  input  logic               inSwizzleEn,
  output logic [ADDR_W-1:0]  outOffset
);

  localparam int BCOL_W = COORD_W + MAX_ELEM_LOG2;
  localparam int PROD_W = COORD_W + PITCH_W;

  // ---------------- stage 1: byte column and tile indices ----------------
  tagMode_e           modeIn;
  logic [2:0]         elemIn;
  logic [BCOL_W-1:0]  byteColIn;

  tagMode_e           s1Mode;
  logic               s1Swz;
  logic [2:0]         s1Elem;
  logic [PITCH_W-1:0] s1Pitch;
  logic [BCOL_W-1:0]  s1ByteCol;
  logic [COORD_W-1:0] s1Y;
  logic [BCOL_W-1:0]  s1TileCol;
  logic [COORD_W-1:0] s1TileRow;

  always_comb begin
    modeIn    = (inMode > 3'd4) ? MODE_LINEAR : tagMode_e'(inMode);
    elemIn    = (inElemLog2 > 3'(MAX_ELEM_LOG2)) ? 3'(MAX_ELEM_LOG2) : inElemLog2;
    byteColIn = BCOL_W'(inX) << elemIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Mode    <= MODE_LINEAR;
      s1Swz     <= 1'b0;
      s1Elem    <= '0;
      s1Pitch   <= '0;
      s1ByteCol <= '0;
      s1Y       <= '0;
      s1TileCol <= '0;
      s1TileRow <= '0;
    end else if (strobe.ld1) begin
      s1Mode    <= modeIn;
      s1Swz     <= inSwizzleEn;
      s1Elem    <= elemIn;
      s1Pitch   <= inPitch;
      s1ByteCol <= byteColIn;
      s1Y       <= inY;
      s1TileCol <= byteColIn >> tileWidthLog2(modeIn);
      s1TileRow <= inY >> tileHeightLog2(modeIn);
    end
  end

  // ---------------- stage 2: pitch multiply and in-tile interleave ----------------
  logic [COORD_W-1:0] mulRow;
  logic [PROD_W-1:0]  rowProd;
  logic [ADDR_W-1:0]  rowBaseNext;
  logic [ADDR_W-1:0]  colPartNext;
  logic [11:0]        intraNext;

  tagMode_e           s2Mode;
  logic               s2Swz;
  logic [2:0]         s2Elem;
  logic [ADDR_W-1:0]  s2RowBase;
  logic [ADDR_W-1:0]  s2ColPart;

  always_comb begin
    mulRow      = (s1Mode == MODE_LINEAR) ? s1Y : s1TileRow;
    rowProd     = PROD_W'(mulRow) * PROD_W'(s1Pitch);
    rowBaseNext = ADDR_W'(rowProd << physRowsLog2(s1Mode));
    intraNext   = intraOffset(s1Mode, s1ByteCol[8:0], s1Y[5:0]);
    if (s1Mode == MODE_LINEAR)
      colPartNext = ADDR_W'(s1ByteCol);
    else
      colPartNext = (ADDR_W'(s1TileCol) << TILE_BYTES_LOG2) | ADDR_W'(intraNext);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2Mode    <= MODE_LINEAR;
      s2Swz     <= 1'b0;
      s2Elem    <= '0;
      s2RowBase <= '0;
      s2ColPart <= '0;
    end else if (strobe.ld2) begin
      s2Mode    <= s1Mode;
      s2Swz     <= s1Swz;
      s2Elem    <= s1Elem;
      s2RowBase <= rowBaseNext;
      s2ColPart <= colPartNext;
    end
  end

  // ---------------- stage 3: final add and channel swizzle ----------------
  logic [ADDR_W-1:0] sumAddr;
  logic [ADDR_W-1:0] swzAddr;

  always_comb begin
    sumAddr = s2RowBase + s2ColPart;
    swzAddr = sumAddr;
    if (s2Swz && s2Mode == MODE_XT)
      swzAddr[6] = sumAddr[6] ^ sumAddr[9] ^ sumAddr[10];
    else if (s2Swz && s2Mode == MODE_YT)
      swzAddr[6] = sumAddr[6] ^ sumAddr[9];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outOffset <= '0;
    else if (strobe.ld3) outOffset <= swzAddr;
  end

  // low byte-column bits below the element size never carry address bits
  assert_lowzero_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((s2ColPart & ((ADDR_W'(1) << s2Elem) - ADDR_W'(1))) == '0));

  assert_holddata_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ld3 |=> $stable(outOffset));

  assert_noswz_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ld3 && (s2Mode == MODE_WT || s2Mode == MODE_T4 || s2Mode == MODE_LINEAR))
      |=> outOffset == $past(s2RowBase + s2ColPart));

endmodule

// File: rtl/tileAddrGen.sv
module tileAddrGen
  import tagPkg::*;
#(
  parameter int COORD_W = 16,
  parameter int PITCH_W = 20,
  parameter int ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [COORD_W-1:0] inX,
  input  logic [COORD_W-1:0] inY,
  input  logic [2:0]         inElemLog2,
  input  logic [PITCH_W-1:0] inPitch,
  input  logic [2:0]         inMode,
  input  logic               inSwizzleEn,
  output logic               outValid,
  input  logic               outReady,
  output logic [ADDR_W-1:0]  outOffset
);

  tagStrobe_t strobe;

  tagCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  tagDatapath #(
    .COORD_W (COORD_W),
    .PITCH_W (PITCH_W),
    .ADDR_W  (ADDR_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .inX         (inX),
    .inY         (inY),
    .inElemLog2  (inElemLog2),
    .inPitch     (inPitch),
    .inMode      (inMode),
    .inSwizzleEn (inSwizzleEn),
    .outOffset   (outOffset)
  );

  assert_stableout_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outOffset));

endmodule

// File: tb/tileAddrGen_tb.sv
module tileAddrGen_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] inX = '0;
  logic [15:0] inY = '0;
  logic [2:0]  inElemLog2 = '0;
  logic [19:0] inPitch = '0;
  logic [2:0]  inMode = '0;
  logic        inSwizzleEn = 1'b0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [31:0] outOffset;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tileAddrGen u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inX(inX), .inY(inY), .inElemLog2(inElemLog2), .inPitch(inPitch),
    .inMode(inMode), .inSwizzleEn(inSwizzleEn), .outValid(outValid),
    .outReady(outReady), .outOffset(outOffset)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // expected offset computed from the requirement text
  function automatic longint model(input int x, input int y, input int e,
                                   input int p, input int m, input bit sw);
    longint bc, u, v, tc, tr, intra, base, a;
    int ee;
    ee = (e > 4) ? 4 : e;
    bc = longint'(x) << ee;
    case (m)
      1: begin
        tc = bc / 512; tr = y / 8; u = bc % 512; v = y % 8;
        intra = v * 512 + u;
        base = tr * p * 8 + tc * 4096;
      end
      2: begin
        tc = bc / 128; tr = y / 32; u = bc % 128; v = y % 32;
        intra = (u / 16) * 512 + v * 16 + (u % 16);
        base = tr * p * 32 + tc * 4096;
      end
      4: begin
        tc = bc / 128; tr = y / 32; u = bc % 128; v = y % 32;
        intra = (u % 16) + (v % 4) * 16 + ((u / 16) % 4) * 64 +
                ((v / 4) % 2) * 256 + ((u / 64) % 2) * 512 + (v / 8) * 1024;
        base = tr * p * 32 + tc * 4096;
      end
      3: begin
        tc = bc / 64; tr = y / 64; u = bc % 64; v = y % 64;
        intra = (u % 2) + (v % 2) * 2 + ((u / 2) % 2) * 4 + ((v / 2) % 2) * 8 +
                ((u / 4) % 2) * 16 + (v / 4) * 32 + (u / 8) * 512;
        base = tr * p * 32 + tc * 4096;
      end
      default: begin
        intra = 0;
        base = longint'(y) * p + bc;
      end
    endcase
    a = (base + intra) & 64'hFFFF_FFFF;
    if (sw && m == 1) a = a ^ ((((a >> 9) ^ (a >> 10)) & 1) << 6);
    if (sw && m == 2) a = a ^ (((a >> 9) & 1) << 6);
    return a;
  endfunction

  // one request with outReady high; result sampled after the second edge past accept
  task automatic runOne(input int x, input int y, input int e, input int p,
                        input int m, input bit sw, output longint res);
    @(negedge clk);
    inX = 16'(x); inY = 16'(y); inElemLog2 = 3'(e); inPitch = 20'(p);
    inMode = 3'(m); inSwizzleEn = sw; inValid = 1'b1; outReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 not early", outValid, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R10 latency", outValid, 1);
    res = outOffset;
  endtask

  task automatic testVal(input string req, input int x, input int y, input int e,
                         input int p, input int m, input bit sw);
    longint r;
    runOne(x, y, e, p, m, sw, r);
    chk(req, r, model(x, y, e, p, m, sw));
  endtask

  task automatic testReset();
    chk("R12 outValid", outValid, 0);
    chk("R12 inReady", inReady, 1);
  endtask

  task automatic testLinear();
    longint r;
    runOne(3, 5, 2, 200, 0, 1'b0, r);
    chk("R1 linear literal", r, 1012);
    runOne(3, 5, 2, 200, 0, 1'b1, r);
    chk("R1 swizzle ignored", r, 1012);
    runOne(7, 9, 0, 300, 5, 1'b1, r);
    chk("R1 unused code as linear", r, 9 * 300 + 7);
  endtask

  task automatic testXTile();
    longint r;
    runOne(1, 1, 0, 1024, 1, 1'b0, r);
    chk("R2 literal", r, 513);
    testVal("R2 tile step", 200, 13, 2, 1024, 1, 1'b0);
    testVal("R2 far tile", 1000, 41, 0, 2048, 1, 1'b0);
  endtask

  task automatic testYTile();
    longint r;
    runOne(16, 1, 0, 512, 2, 1'b0, r);
    chk("R3 literal", r, 528);
    testVal("R3 tile step", 45, 70, 1, 512, 2, 1'b0);
  endtask

  task automatic testT4();
    testVal("R4 shuffle", 37, 27, 2, 512, 4, 1'b0);
    testVal("R4 tile step", 120, 41, 0, 512, 4, 1'b0);
  endtask

  task automatic testWTile();
    testVal("R5 in tile", 63, 63, 0, 256, 3, 1'b0);
    testVal("R5 row 64 step", 70, 130, 0, 256, 3, 1'b0);
    testVal("R5 bits", 21, 45, 0, 256, 3, 1'b0);
  endtask

  task automatic testElem();
    longint r;
    runOne(3, 0, 4, 1024, 1, 1'b0, r);
    chk("R6 16B column", r, 48);
    runOne(5, 2, 3, 512, 2, 1'b0, r);
    chk("R6 8B low bits zero", r & 7, 0);
    chk("R6 8B value", r, model(5, 2, 3, 512, 2, 1'b0));
  endtask

  task automatic testAdjacent();
    longint a, b;
    runOne(5, 2, 2, 1024, 1, 1'b0, a);
    runOne(5, 3, 2, 1024, 1, 1'b0, b);
    chk("R7 vertical stride", b - a, 512);
  endtask

  task automatic testSwizzle();
    longint r, q;
    runOne(0, 1, 0, 1024, 1, 1'b1, r);
    chk("R8 bit9 only", r, 576);
    runOne(0, 3, 0, 1024, 1, 1'b1, r);
    chk("R8 bits 9 and 10 cancel", r, 1536);
    runOne(0, 2, 0, 1024, 1, 1'b1, r);
    chk("R8 bit10 only", r, 1024 + 64);
    runOne(16, 1, 0, 512, 2, 1'b1, r);
    chk("R9 column tile bit9", r, 592);
    runOne(0, 0, 0, 512, 2, 1'b1, r);
    chk("R9 column tile no bit9", r, 0);
    runOne(21, 45, 0, 256, 3, 1'b0, q);
    runOne(21, 45, 0, 256, 3, 1'b1, r);
    chk("R9 interleaved mode ignores swizzle", r, q);
    runOne(120, 41, 0, 512, 4, 1'b0, q);
    runOne(120, 41, 0, 512, 4, 1'b1, r);
    chk("R9 shuffled mode ignores swizzle", r, q);
  endtask

  task automatic testStall();
    int ys[3] = '{1, 2, 3};
    @(negedge clk);
    outReady = 1'b0;
    for (int i = 0; i < 3; i++) begin
      inX = 16'd4; inY = 16'(ys[i]); inElemLog2 = 3'd0; inPitch = 20'd1024;
      inMode = 3'd1; inSwizzleEn = 1'b0; inValid = 1'b1;
      chk("R11 ready while filling", inReady, 1);
      @(posedge clk);
      @(negedge clk);
    end
    inValid = 1'b0;
    chk("R11 inReady low when full", inReady, 0);
    chk("R11 outValid while stalled", outValid, 1);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
    chk("R11 offset held", outOffset, model(4, 1, 0, 1024, 1, 1'b0));
    chk("R11 valid held", outValid, 1);
    outReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R10 back-to-back second", outOffset, model(4, 2, 0, 1024, 1, 1'b0));
    chk("R10 back-to-back valid", outValid, 1);
    @(posedge clk);
    @(negedge clk);
    chk("R10 back-to-back third", outOffset, model(4, 3, 0, 1024, 1, 1'b0));
    @(posedge clk);
    @(negedge clk);
    chk("R11 no duplicate", outValid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLinear();
    testXTile();
    testYTile();
    testT4();
    testWTile();
    testElem();
    testAdjacent();
    testSwizzle();
    testStall();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule